// File: doc/BRIEF.md
# Modulo 2^N-1 Triple Generator

This block computes three times an N-bit residue modulo the Mersenne-form modulus 2^N-1. It is the hard-multiple source for a radix-8 Booth modulo multiplier: the partial-product selectors need 3X ready before any selection takes place, and every other multiple is a rotation or an inversion of X. The value is formed as X plus 2X. Doubling modulo 2^N-1 is a cyclic one-bit left rotation, so the only real arithmetic is a single N-bit end-around-carry addition.

That addition uses a parallel-prefix structure. A first stage pairs each operand bit with its rotated neighbour and forms generate, propagate and half-sum signals. A cyclic prefix network then resolves every carry, with the carry out of the top bit feeding back into bit 0. A last stage XORs each half-sum with the carry from the bit below. The block is purely combinational and has no clock. Zero has two forms in this arithmetic, all zeros and all ones, and either may appear on the output.

The house preference for valid/ready streams does not apply here. The block has no storage and no latency, so a handshake would only pass straight through. The ports are plain data.

Top module: `triple_mod_mersenne`

## Requirements
- R1: For every input value X, the output is congruent to 3*X modulo 2^N-1.
- R2: When the input is all zeros, the output is a zero encoding, either all zeros or all ones.
- R3: When the input is all ones (the second zero encoding), the output is a zero encoding.
- R4: When the input has exactly one bit k set, the output has exactly bits k and (k+1) mod N set. For k = N-1 this places the second bit at position 0.
- R5: R1 holds for an odd width (N = 5) as well as for N = 8. The prefix network must be correct when N is not a power of two.
- R6: When the true result is zero, the output may be either zero encoding, and both count as correct. For N = 8, X = 85 and X = 170 give results of this kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| resid_i | input | WIDTH | Residue X modulo 2^WIDTH-1; all ones is accepted as zero |
| triple_o | output | WIDTH | 3*X modulo 2^WIDTH-1; zero may appear as all zeros or all ones |

## Verification
The immediate assertions assume that the input carries a known value. Each assertion is skipped while any input bit is X or Z. The bench therefore drives the input to zero before the first evaluation and only ever applies fully defined values. The congruence assertion also assumes that WIDTH stays small enough for a WIDTH+2-bit remainder calculation. Both instances in the bench are swept over every possible input, so every assertion sees the complete input space of each width.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  // Number of cyclic prefix levels needed for an n-bit end-around carry.
  function automatic int unsigned tmm_levels(input int unsigned n);
    int unsigned lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    return lv;
  endfunction
endpackage

// File: rtl/tmm_pre.sv
module tmm_pre #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] half_o
);
  logic [WIDTH-1:0] dbl;

  // 2X mod 2^WIDTH-1 is a cyclic left rotation by one bit.
  assign dbl    = {x_i[WIDTH-2:0], x_i[WIDTH-1]};
  assign gen_o  = x_i & dbl;
  assign prop_o = x_i | dbl;
  assign half_o = x_i ^ dbl;

  always_comb begin
    if (!$isunknown(x_i)) begin
      AST_PRE_ZERO_QUIET: assert ((x_i != '0) || ((gen_o == '0) && (prop_o == '0))); // R2
    end
  end
endmodule

// File: rtl/tmm_prefix.sv
module tmm_prefix
  import tmm_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] carry_o
);
  localparam int unsigned LEVELS = tmm_levels(WIDTH);

  logic [LEVELS:0][WIDTH-1:0] grp_g;
  logic [LEVELS:0][WIDTH-1:0] grp_p;

  assign grp_g[0] = gen_i;
  assign grp_p[0] = prop_i;

  // Cyclic Kogge-Stone: each node combines with the node 2^lv places below,
  // wrapping past bit 0, so the top carry feeds back into the low bits.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int unsigned DIST = 1 << lv;
    for (genvar i = 0; i < WIDTH; i++) begin : g_node
      localparam int unsigned LOW = (i + WIDTH - DIST) % WIDTH;
      assign grp_g[lv+1][i] = grp_g[lv][i] | (grp_p[lv][i] & grp_g[lv][LOW]);
      assign grp_p[lv+1][i] = grp_p[lv][i] & grp_p[lv][LOW];
    end
  end

  assign carry_o = grp_g[LEVELS];

  always_comb begin
    if (!$isunknown({gen_i, prop_i})) begin
      AST_NO_GEN_NO_CARRY: assert ((gen_i != '0) || (carry_o == '0)); // R2
      AST_ALL_GEN_ALL_CARRY: assert ((gen_i != '1) || (carry_o == '1)); // R3
    end
  end
endmodule

// File: rtl/tmm_post.sv
module tmm_post #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] cin;

  // Carry into bit i comes from bit i-1; bit 0 takes the end-around carry.
  assign cin   = {carry_i[WIDTH-2:0], carry_i[WIDTH-1]};
  assign sum_o = half_i ^ cin;

  always_comb begin
    if (!$isunknown({half_i, carry_i})) begin
      AST_SATURATED_ONES: assert (!((half_i == '0) && (carry_i == '1)) || (sum_o == '1)); // R3
    end
  end
endmodule

// File: rtl/triple_mod_mersenne.sv
module triple_mod_mersenne #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] resid_i,
  output logic [WIDTH-1:0] triple_o
);
  localparam int unsigned XW = WIDTH + 2;
  localparam logic [XW-1:0] MODV = {2'b00, {WIDTH{1'b1}}};

  logic [WIDTH-1:0] gen, prop, half, carry;

  tmm_pre #(.WIDTH(WIDTH)) u_pre (
    .x_i   (resid_i),
    .gen_o (gen),
    .prop_o(prop),
    .half_o(half)
  );

  tmm_prefix #(.WIDTH(WIDTH)) u_prefix (
    .gen_i  (gen),
    .prop_i (prop),
    .carry_o(carry)
  );

  tmm_post #(.WIDTH(WIDTH)) u_post (
    .half_i (half),
    .carry_i(carry),
    .sum_o  (triple_o)
  );

  logic [XW-1:0] want_mod, got_mod;
  always_comb begin
    want_mod = ({2'b00, resid_i} + {1'b0, resid_i, 1'b0}) % MODV;
    got_mod  = {2'b00, triple_o} % MODV;
    if (!$isunknown(resid_i)) begin
      AST_CONGRUENT: assert (want_mod == got_mod); // R1
      AST_ZERO_IN: assert ((resid_i != '0) || (triple_o == '0) || (triple_o == '1)); // R2
      AST_ONES_IN: assert ((resid_i != '1) || (triple_o == '0) || (triple_o == '1)); // R3
      if (WIDTH >= 3) begin
        AST_SINGLE_BIT: assert (($countones(resid_i) != 1) || ($countones(triple_o) == 2)); // R4
      end
    end
  end
endmodule

// File: tb/triple_mod_mersenne_bench.sv
module triple_mod_mersenne_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 8;
  localparam int WB = 5;

  typedef struct {
    int    xa;
    int    ea;
    int    xb;
    int    eb;
    string tag;
  } item_t;

  logic clk = 0;
  logic rst = 1;
  logic [WA-1:0] xa = '0;
  logic [WB-1:0] xb = '0;
  logic [WA-1:0] ya;
  logic [WB-1:0] yb;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  triple_mod_mersenne #(.WIDTH(WA)) u_triple_mod_mersenne (.resid_i(xa), .triple_o(ya));
  triple_mod_mersenne #(.WIDTH(WB)) u_triple_mod_mersenne_odd (.resid_i(xb), .triple_o(yb));

  function automatic int ref3(int x, int w);
    int m;
    m = (1 << w) - 1;
    return (3 * x) % m;
  endfunction

  function automatic bit match(int got, int exp, int w);
    return (got == exp) || (exp == 0 && got == ((1 << w) - 1));
  endfunction

  task automatic drive(int a, int b, string tag);
    item_t it;
    @(posedge clk);
    #1;
    xa = a[WA-1:0];
    xb = b[WB-1:0];
    it.xa = a; it.ea = ref3(a, WA);
    it.xb = b; it.eb = ref3(b, WB);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (!match(int'(ya), it.ea, WA)) begin
          errors++;
          $display("FAIL %s: W=%0d x=%0d got=%0d exp=%0d", it.tag, WA, it.xa, ya, it.ea);
        end
        checks++;
        if (!match(int'(yb), it.eb, WB)) begin
          errors++;
          $display("FAIL %s: W=%0d x=%0d got=%0d exp=%0d", it.tag, WB, it.xb, yb, it.eb);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    // R2: all-zero input yields a zero encoding (first check after reset)
    drive(0, 0, "R2");
    // R3: all-ones input is the other zero encoding
    drive((1 << WA) - 1, (1 << WB) - 1, "R3");
    // R4: single set bit, including the wrap from the top bit to bit 0
    for (int k = 0; k < WA; k++) drive(1 << k, 1 << (k % WB), "R4");
    // R6: results that are zero although the input is not
    drive(85, 0, "R6");
    drive(170, 31, "R6");
    // R1 and R5: exhaustive sweep of both widths
    for (int i = 0; i < (1 << WA); i++) drive(i, i % (1 << WB), "R1_R5");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule